// File: doc/BRIEF.md
# Frequency Change Command Controller

This block is a command unit for clock and voltage changes. Software writes a 16-bit control word. The word holds an opcode, a launch/busy bit, a frequency level, a mode flag and a voltage ID. A write with the launch bit clear only stages the fields. A write with the launch bit set, made while the unit is idle, starts the staged command.

The launch bit then reads back as a busy flag. An internal completion timer stands in for the clock and voltage subsystem. When the timer runs out it acknowledges the command: busy clears and the command's side effect is applied to the status outputs. Software is expected to poll until busy reads 0 before it issues the next command.

Writes made while a command is in flight have no effect. A launch attempted during that time raises a sticky rejection flag. Opcodes 6 and 7 are not legal. They finish at once with no side effect and raise a sticky error flag. A read strobe clears both sticky flags.

Top module: `freq_cmd_ctrl`

## Requirements
- R1: After reset the unit is idle (busy 0) and both sticky flags are 0. Frequency level equals `start_level`, the render clock is on, the regulator is on, and the voltage ID is 0.
- R2: The control word layout is opcode in bits 15:13, launch/busy in bit 12, frequency level in 11:8, mode in 7 and voltage ID in 6:0. An idle write with bit 12 = 0 stores the frequency, mode and voltage fields, which read back at those positions in `ctrl_rd`, and starts nothing.
- R3: An idle write with bit 12 = 1 and a legal opcode (0 to 5) makes busy read 1 from the next cycle. Busy stays 1 for `cmd_delay`+1 cycles and then clears.
- R4: Opcode 2 sets `cur_freq` to the staged frequency level in the cycle busy clears. Before that cycle `cur_freq` keeps its old value.
- R5: Opcode 3 sets `cur_vid` to the staged voltage ID on completion.
- R6: Opcode 0 turns `render_clk_on` off on completion, and opcode 1 turns it on.
- R7: Opcode 4 turns `regulator_on` off on completion, and opcode 5 turns it on.
- R8: While busy, every write is ignored. The staged fields and the result of the command in flight are unchanged. A write with bit 12 = 1 during that time sets `flag_rejected`.
- R9: `flag_rejected` and `flag_illegal` hold until a cycle with `rd_en` = 1, which clears them. A new set event in the same cycle wins over the clear.
- R10: An idle launch with opcode 6 or 7 leaves busy at 0, changes none of the status outputs, and sets `flag_illegal`.
- R11: `ctrl_rd[15:13]` reports the opcode of the most recently accepted launch, legal or illegal. It is 0 after reset.
- R12: The mode bit (bit 7) is stored with the other fields and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_level | input | 4 | Frequency level loaded at reset |
| cmd_delay | input | 8 | Completion time: busy lasts this value plus one cycles |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word written |
| rd_en | input | 1 | Status read strobe; clears the sticky flags |
| ctrl_rd | output | 16 | Readback: last opcode, busy, staged frequency, mode, voltage ID |
| busy | output | 1 | Command in flight |
| cur_freq | output | 4 | Applied frequency level |
| cur_vid | output | 7 | Applied voltage ID |
| render_clk_on | output | 1 | Render clock state |
| regulator_on | output | 1 | Regulator state |
| flag_rejected | output | 1 | Sticky: launch attempted while busy |
| flag_illegal | output | 1 | Sticky: illegal opcode launched |

## Verification
Each legal opcode is launched from idle. The delays used are zero and non-zero. The outputs are sampled one cycle before and one cycle after completion, which separates an off-by-one timer from a correct one and an early side effect from one applied at completion. Two kinds of write are then issued in the middle of a command: a staging-only write and a launch attempt. The bench looks at both the staged readback and the final applied level, so a rejected write that leaks into the fields is caught. The illegal opcodes are sent from idle to show that they finish with no busy cycle and no state change. A separate read strobe then shows that the sticky flags clear.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int OP_W   = 3;
  localparam int FREQ_W = 4;
  localparam int VID_W  = 7;
  localparam int CTRL_W = OP_W + 1 + FREQ_W + 1 + VID_W;
  localparam int START_BIT = CTRL_W - OP_W - 1;

  typedef enum logic [OP_W-1:0] {
    OP_CLK_OFF  = 3'd0,
    OP_CLK_ON   = 3'd1,
    OP_SET_FREQ = 3'd2,
    OP_SET_VID  = 3'd3,
    OP_REG_OFF  = 3'd4,
    OP_REG_ON   = 3'd5,
    OP_RSV6     = 3'd6,
    OP_RSV7     = 3'd7
  } fcc_op_e;

  typedef struct packed {
    fcc_op_e            op;
    logic [FREQ_W-1:0]  freq;
    logic               mode;
    logic [VID_W-1:0]   vid;
  } fcc_fields_t;
endpackage

// File: rtl/fcc_ctrl_reg.sv
module fcc_ctrl_reg
  import fcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic              busy_i,
  output fcc_fields_t       fields_o,
  output fcc_op_e           last_op_o,
  output logic              launch_o,
  output logic              rej_o,
  output logic              ill_o
);
  fcc_fields_t wr_fields;
  logic        wr_start;
  logic        op_bad;
  logic        accept;
  logic        rej_set, ill_set;
  fcc_fields_t fld_q;
  fcc_op_e     last_q;
  logic        rej_q, ill_q;

  always_comb begin
    wr_fields.op   = fcc_op_e'(wr_data_i[CTRL_W-1 -: OP_W]);
    wr_fields.freq = wr_data_i[START_BIT-1 -: FREQ_W];
    wr_fields.mode = wr_data_i[VID_W];
    wr_fields.vid  = wr_data_i[VID_W-1:0];
    wr_start       = wr_data_i[START_BIT];
    op_bad         = (wr_fields.op == OP_RSV6) || (wr_fields.op == OP_RSV7);
    accept         = wr_en_i && !busy_i;
    launch_o       = accept && wr_start && !op_bad;
    ill_set        = accept && wr_start && op_bad;
    rej_set        = wr_en_i && wr_start && busy_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fld_q  <= '0;
      last_q <= OP_CLK_OFF;
      rej_q  <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      if (accept) fld_q <= wr_fields;
      if (accept && wr_start) last_q <= wr_fields.op;
      rej_q <= rej_set | (rej_q & ~rd_en_i);
      ill_q <= ill_set | (ill_q & ~rd_en_i);
    end
  end

  assign fields_o  = fld_q;
  assign last_op_o = last_q;
  assign rej_o     = rej_q;
  assign ill_o     = ill_q;

  p_fields_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> (fld_q == $past(fld_q)));
  p_reject_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_start && busy_i) |=> rej_q);
  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !(wr_en_i && wr_start)) |=> (!rej_q && !ill_q));
endmodule

// File: rtl/fcc_timer.sv
module fcc_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             busy_o,
  output logic             done_o
);
  logic             busy_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      cnt_q  <= delay_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  p_launch_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |=> busy_o);
  p_no_launch_in_flight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> !busy_q);
  p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
endmodule

// File: rtl/fcc_apply.sv
module fcc_apply
  import fcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  fcc_fields_t       fields_i,
  input  logic [FREQ_W-1:0] start_level_i,
  output logic [FREQ_W-1:0] freq_o,
  output logic [VID_W-1:0]  vid_o,
  output logic              clk_on_o,
  output logic              reg_on_o
);
  logic [FREQ_W-1:0] freq_q;
  logic [VID_W-1:0]  vid_q;
  logic              clk_on_q, reg_on_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_q   <= start_level_i;
      vid_q    <= '0;
      clk_on_q <= 1'b1;
      reg_on_q <= 1'b1;
    end else if (done_i) begin
      case (fields_i.op)
        OP_CLK_OFF:  clk_on_q <= 1'b0;
        OP_CLK_ON:   clk_on_q <= 1'b1;
        OP_SET_FREQ: freq_q   <= fields_i.freq;
        OP_SET_VID:  vid_q    <= fields_i.vid;
        OP_REG_OFF:  reg_on_q <= 1'b0;
        OP_REG_ON:   reg_on_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign freq_o   = freq_q;
  assign vid_o    = vid_q;
  assign clk_on_o = clk_on_q;
  assign reg_on_o = reg_on_q;

  p_freq_only_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> $stable(freq_q));
  p_vid_only_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> $stable(vid_q));
endmodule

// File: rtl/freq_cmd_ctrl.sv
module freq_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] start_level,
  input  logic [DLY_W-1:0]  cmd_delay,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic              busy,
  output logic [FREQ_W-1:0] cur_freq,
  output logic [VID_W-1:0]  cur_vid,
  output logic              render_clk_on,
  output logic              regulator_on,
  output logic              flag_rejected,
  output logic              flag_illegal
);
  fcc_fields_t fields;
  fcc_op_e     last_op;
  logic        launch, done;

  fcc_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .busy_i(busy), .fields_o(fields), .last_op_o(last_op),
    .launch_o(launch), .rej_o(flag_rejected), .ill_o(flag_illegal)
  );

  fcc_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .delay_i(cmd_delay),
    .busy_o(busy), .done_o(done)
  );

  fcc_apply u_app (
    .clk(clk), .rst_n(rst_n), .done_i(done), .fields_i(fields),
    .start_level_i(start_level), .freq_o(cur_freq), .vid_o(cur_vid),
    .clk_on_o(render_clk_on), .reg_on_o(regulator_on)
  );

  assign ctrl_rd = {last_op, busy, fields.freq, fields.mode, fields.vid};

  p_illegal_stays_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[START_BIT] && !busy && (wr_data[CTRL_W-1 -: OP_W] >= 3'd6))
    |=> (!busy && flag_illegal && $stable(cur_freq) && $stable(render_clk_on)));
endmodule

// File: tb/tb_freq_cmd_ctrl.sv
module tb_freq_cmd_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  start_level = 4'd5;
  logic [7:0]  cmd_delay = 8'd0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] ctrl_rd;
  logic        busy, render_clk_on, regulator_on, flag_rejected, flag_illegal;
  logic [3:0]  cur_freq;
  logic [6:0]  cur_vid;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  freq_cmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start_level(start_level), .cmd_delay(cmd_delay),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .ctrl_rd(ctrl_rd),
    .busy(busy), .cur_freq(cur_freq), .cur_vid(cur_vid),
    .render_clk_on(render_clk_on), .regulator_on(regulator_on),
    .flag_rejected(flag_rejected), .flag_illegal(flag_illegal)
  );

  function automatic logic [15:0] mk(int op, int st, int fq, int md, int vid);
    return {op[2:0], st[0], fq[3:0], md[0], vid[6:0]};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 freq", cur_freq, 5);
    chk("R1 clk on", render_clk_on, 1);
    chk("R1 reg on", regulator_on, 1);
    chk("R1 vid", cur_vid, 0);
    chk("R1 flags", {flag_rejected, flag_illegal}, 0);
    chk("R11 last op reset", ctrl_rd[15:13], 0);
  endtask

  task automatic t_stage();
    wr(mk(3, 0, 12, 1, 7'h55));
    chk("R2 no launch", busy, 0);
    chk("R2 freq field", ctrl_rd[11:8], 12);
    chk("R2 vid field", ctrl_rd[6:0], 'h55);
    chk("R12 mode bit", ctrl_rd[7], 1);
    wait_n(2);
    chk("R2 vid unchanged", cur_vid, 0);
  endtask

  task automatic t_freq();
    cmd_delay = 8'd3;
    wr(mk(2, 1, 9, 0, 0));
    chk("R3 busy set", busy, 1);
    chk("R3 busy bit readback", ctrl_rd[12], 1);
    wait_n(3);
    chk("R3 busy held", busy, 1);
    chk("R4 freq before done", cur_freq, 5);
    wait_n(1);
    chk("R3 busy clear", busy, 0);
    chk("R4 freq applied", cur_freq, 9);
    chk("R11 last op", ctrl_rd[15:13], 2);
  endtask

  task automatic t_vid();
    cmd_delay = 8'd0;
    wr(mk(3, 1, 0, 0, 7'h2A));
    chk("R3 zero delay busy", busy, 1);
    chk("R12 mode cleared", ctrl_rd[7], 0);
    wait_n(1);
    chk("R3 zero delay done", busy, 0);
    chk("R5 vid applied", cur_vid, 'h2A);
    chk("R5 freq untouched", cur_freq, 9);
  endtask

  task automatic t_clock();
    cmd_delay = 8'd1;
    wr(mk(0, 1, 0, 0, 0)); wait_n(2);
    chk("R6 clock off", render_clk_on, 0);
    chk("R6 regulator untouched", regulator_on, 1);
    wr(mk(1, 1, 0, 0, 0)); wait_n(2);
    chk("R6 clock on", render_clk_on, 1);
  endtask

  task automatic t_regulator();
    cmd_delay = 8'd2;
    wr(mk(4, 1, 0, 0, 0)); wait_n(3);
    chk("R7 regulator off", regulator_on, 0);
    chk("R7 clock untouched", render_clk_on, 1);
    wr(mk(5, 1, 0, 0, 0)); wait_n(3);
    chk("R7 regulator on", regulator_on, 1);
  endtask

  task automatic t_busy_reject();
    cmd_delay = 8'd6;
    wr(mk(2, 1, 11, 0, 0));
    wr(mk(2, 0, 4, 1, 3));
    chk("R8 staging ignored", ctrl_rd[11:7], {4'd11, 1'b0});
    chk("R8 no reject on stage", flag_rejected, 0);
    wr(mk(0, 1, 2, 0, 0));
    chk("R8 reject flag", flag_rejected, 1);
    chk("R8 still busy", busy, 1);
    chk("R11 last op kept", ctrl_rd[15:13], 2);
    wait_n(6);
    chk("R8 done", busy, 0);
    chk("R8 in-flight result", cur_freq, 11);
    chk("R8 clock untouched", render_clk_on, 1);
    chk("R9 flag sticky", flag_rejected, 1);
    rd();
    chk("R9 reject cleared by read", flag_rejected, 0);
  endtask

  task automatic t_illegal();
    wr(mk(6, 1, 1, 0, 1));
    chk("R10 no busy", busy, 0);
    chk("R10 error flag", flag_illegal, 1);
    chk("R10 freq untouched", cur_freq, 11);
    chk("R10 vid untouched", cur_vid, 'h2A);
    chk("R11 last op illegal", ctrl_rd[15:13], 6);
    wait_n(3);
    chk("R10 still idle", busy, 0);
    chk("R9 illegal sticky", flag_illegal, 1);
    rd();
    chk("R9 illegal cleared", flag_illegal, 0);
    wr(mk(7, 1, 0, 0, 0));
    chk("R10 opcode 7 flag", flag_illegal, 1);
    chk("R10 opcode 7 clk", render_clk_on, 1);
    chk("R10 opcode 7 reg", regulator_on, 1);
    rd();
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_stage();
    t_freq();
    t_vid();
    t_clock();
    t_regulator();
    t_busy_reject();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule